// File: doc/BRIEF.md
# Radio Transceiver State Sequencer

This block is the control state machine for a low-power radio front end. A host issues commands over a simple valid/code strobe and drives a sleep pin. The block steps between RESET, SLEEP, TRX_OFF, PLL_ON, RX_ON and BUSY_TX. Each move that needs analog settling time is modelled as a down-counter. While that counter runs, the block reports a separate transition code. The target state is reported only once the settling time has elapsed.

Almost all settling delays are counted in pulses of a free-running microsecond tick input. The one exception is the descent into SLEEP, which is counted in system clock cycles. That delay is derived from the ratio of the system clock to the output clock frequency. Two force commands act at once, even in the middle of a transition. Each has its own set of states in which it is honoured. A transmit start raises BUSY_TX at once and emits a one-cycle strobe when the first symbol is due. Illegal commands set a sticky error flag.

Top module: `radio_state_seq`

## Requirements
- R1: The active-low asynchronous reset puts the block in RESET (state code 0) with cmd_err low. The block moves to TRX_OFF on the 37th tick after reset is released.
- R2: state_code uses these values: 0 RESET, 1 SLEEP, 2 TRX_OFF, 3 PLL_ON, 4 RX_ON, 5 BUSY_TX, 7 TRANSITION. busy is high exactly while the code is 7.
- R3: cmd_code is sampled when cmd_valid is high. The codes are: 1 go TRX_OFF, 2 go PLL_ON, 3 go RX_ON, 4 transmit start, 5 force TRX_OFF, 6 force PLL_ON. Codes 0 and 7 do nothing. From TRX_OFF, code 2 or 3 enters TRANSITION, and the target is reported on the 110th tick.
- R4: The moves PLL_ON to RX_ON, RX_ON to PLL_ON, PLL_ON to TRX_OFF and RX_ON to TRX_OFF each pass through TRANSITION and complete on the first tick.
- R5: In PLL_ON, either code 4 or a rising edge of slp_pin enters BUSY_TX in the next cycle. tx_strobe then pulses for one cycle on the 16th tick.
- R6: In BUSY_TX after the strobe, tx_done enters TRANSITION, and PLL_ON is reported on the 32nd tick. A tx_done before the strobe is ignored.
- R7: In TRX_OFF with no command, a high slp_pin enters TRANSITION. SLEEP is reported after 35*(CLK_HZ/CLKM_HZ) clock cycles.
- R8: In SLEEP, a low slp_pin enters TRANSITION, and TRX_OFF is reported on the 240th tick. wake_irq is high for exactly the first TRX_OFF cycle.
- R9: Code 5 in RESET, PLL_ON, RX_ON, BUSY_TX or TRANSITION reaches TRX_OFF on the first tick, aborting any running transition. In SLEEP it has no effect.
- R10: Code 6 in RX_ON, BUSY_TX or TRANSITION reaches PLL_ON on the first tick. In SLEEP, RESET and TRX_OFF it changes nothing and sets no error.
- R11: Codes 1 to 4 received during TRANSITION are discarded. They do not change the target and do not set cmd_err.
- R12: Codes 1 to 4 in SLEEP, RESET or BUSY_TX, and code 4 in TRX_OFF or RX_ON, leave the state unchanged and set cmd_err. cmd_err stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code |
| slp_pin | input | 1 | Sleep / transmit pin level |
| tx_done | input | 1 | Transmission finished |
| state_code | output | 3 | Reported state |
| busy | output | 1 | Transition in progress |
| wake_irq | output | 1 | One-cycle pulse on wake to TRX_OFF |
| tx_strobe | output | 1 | One-cycle first-symbol strobe |
| cmd_err | output | 1 | Sticky illegal-command flag |

## Verification
The bench keeps every microsecond delay at its default value. It drives us_tick itself, so each microsecond costs two clock cycles. This keeps the full 240- and 110-tick settles cheap enough to check on both sides of the completing tick. The bench sets CLKM_HZ to 4 MHz against a 100 MHz CLK_HZ, so the clock-counted sleep entry becomes 875 cycles and both its last waiting cycle and its arrival are observed. A random walk over TRX_OFF, PLL_ON and RX_ON mixes every command code with the sticky error flag.

// File: rtl/radio_state_seq.sv
module radio_state_seq #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int CLKM_HZ     = 1_000_000,
  parameter int SLP_PERIODS = 35,
  parameter int T_RST       = 37,
  parameter int T_WAKE      = 240,
  parameter int T_LONG      = 110,
  parameter int T_FAST      = 1,
  parameter int T_TX_LEAD   = 16,
  parameter int T_TX_END    = 32,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       us_tick,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       slp_pin,
  input  logic       tx_done,
  output logic [2:0] state_code,
  output logic       busy,
  output logic       wake_irq,
  output logic       tx_strobe,
  output logic       cmd_err
);
  localparam logic [2:0] S_RST = 3'd0, S_SLP = 3'd1, S_OFF = 3'd2, S_PLL = 3'd3,
                         S_RX  = 3'd4, S_TX  = 3'd5, S_TRN = 3'd7;
  localparam logic [2:0] K_OFF = 3'd1, K_PLL = 3'd2, K_RX = 3'd3, K_TX = 3'd4,
                         K_FOFF = 3'd5, K_FPLL = 3'd6;
  localparam logic [CNT_W-1:0] C_RST  = CNT_W'(T_RST);
  localparam logic [CNT_W-1:0] C_WAKE = CNT_W'(T_WAKE);
  localparam logic [CNT_W-1:0] C_LONG = CNT_W'(T_LONG);
  localparam logic [CNT_W-1:0] C_FAST = CNT_W'(T_FAST);
  localparam logic [CNT_W-1:0] C_LEAD = CNT_W'(T_TX_LEAD);
  localparam logic [CNT_W-1:0] C_TXE  = CNT_W'(T_TX_END);
  localparam logic [CNT_W-1:0] C_SLP  = CNT_W'((CLK_HZ / CLKM_HZ) * SLP_PERIODS);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);

  logic [2:0]       cur, tgt;
  logic [CNT_W-1:0] cnt;
  logic             by_clk, waking, sent, slp_q, err;

  wire plain  = cmd_valid && (cmd_code >= K_OFF) && (cmd_code <= K_TX);
  wire f_off  = cmd_valid && (cmd_code == K_FOFF);
  wire f_pll  = cmd_valid && (cmd_code == K_FPLL);
  wire pll_ok = (cur == S_RX) || (cur == S_TX) || (cur == S_TRN);
  wire last   = (cnt == ONE);

  assign state_code = cur;
  assign busy       = (cur == S_TRN);
  assign cmd_err    = err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur       <= S_RST;
      tgt       <= S_OFF;
      cnt       <= C_RST;
      by_clk    <= 1'b0;
      waking    <= 1'b0;
      sent      <= 1'b0;
      slp_q     <= 1'b0;
      err       <= 1'b0;
      wake_irq  <= 1'b0;
      tx_strobe <= 1'b0;
    end else begin
      slp_q     <= slp_pin;
      wake_irq  <= 1'b0;
      tx_strobe <= 1'b0;
      if (f_off && cur != S_SLP) begin
        if (cur != S_OFF) begin
          cur <= S_TRN; tgt <= S_OFF; cnt <= C_FAST; by_clk <= 1'b0; waking <= 1'b0;
        end
      end else if (f_pll && pll_ok) begin
        cur <= S_TRN; tgt <= S_PLL; cnt <= C_FAST; by_clk <= 1'b0; waking <= 1'b0;
      end else begin
        case (cur)
          S_RST: begin
            if (plain) err <= 1'b1;
            if (us_tick) begin
              if (last) cur <= S_OFF;
              else cnt <= cnt - ONE;
            end
          end
          S_SLP: begin
            if (plain) err <= 1'b1;
            if (!slp_pin) begin
              cur <= S_TRN; tgt <= S_OFF; cnt <= C_WAKE; by_clk <= 1'b0; waking <= 1'b1;
            end
          end
          S_OFF: begin
            if (plain) begin
              case (cmd_code)
                K_PLL: begin cur <= S_TRN; tgt <= S_PLL; cnt <= C_LONG; by_clk <= 1'b0; end
                K_RX:  begin cur <= S_TRN; tgt <= S_RX;  cnt <= C_LONG; by_clk <= 1'b0; end
                K_TX:  err <= 1'b1;
                default: ;
              endcase
            end else if (slp_pin) begin
              cur <= S_TRN; tgt <= S_SLP; cnt <= C_SLP; by_clk <= 1'b1;
            end
          end
          S_PLL: begin
            if (plain) begin
              case (cmd_code)
                K_OFF: begin cur <= S_TRN; tgt <= S_OFF; cnt <= C_FAST; by_clk <= 1'b0; end
                K_RX:  begin cur <= S_TRN; tgt <= S_RX;  cnt <= C_FAST; by_clk <= 1'b0; end
                K_TX:  begin cur <= S_TX; cnt <= C_LEAD; sent <= 1'b0; end
                default: ;
              endcase
            end else if (slp_pin && !slp_q) begin
              cur <= S_TX; cnt <= C_LEAD; sent <= 1'b0;
            end
          end
          S_RX: begin
            if (plain) begin
              case (cmd_code)
                K_OFF: begin cur <= S_TRN; tgt <= S_OFF; cnt <= C_FAST; by_clk <= 1'b0; end
                K_PLL: begin cur <= S_TRN; tgt <= S_PLL; cnt <= C_FAST; by_clk <= 1'b0; end
                K_TX:  err <= 1'b1;
                default: ;
              endcase
            end
          end
          S_TX: begin
            if (plain) err <= 1'b1;
            if (!sent) begin
              if (us_tick) begin
                if (last) begin tx_strobe <= 1'b1; sent <= 1'b1; end
                else cnt <= cnt - ONE;
              end
            end else if (tx_done) begin
              cur <= S_TRN; tgt <= S_PLL; cnt <= C_TXE; by_clk <= 1'b0;
            end
          end
          S_TRN: begin
            if (by_clk || us_tick) begin
              if (last) begin
                cur      <= tgt;
                wake_irq <= waking;
                waking   <= 1'b0;
                by_clk   <= 1'b0;
              end else cnt <= cnt - ONE;
            end
          end
          default: cur <= S_RST;
        endcase
      end
    end
  end
endmodule

// File: rtl/radio_state_seq_chk.sv
module radio_state_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       us_tick,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic [2:0] state_code,
  input logic       wake_irq,
  input logic       tx_strobe,
  input logic       cmd_err
);
  AST_RESET_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 3'd0 |=> state_code == 3'd0 || state_code == 3'd2 || state_code == 3'd7); // R1
  AST_TRANS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_code) == 3'd7 && state_code != 3'd7 && state_code != 3'd1) |-> $past(us_tick)); // R2
  AST_TX_FROM_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 3'd5 && $past(state_code) != 3'd5) |-> $past(state_code) == 3'd3); // R5
  AST_STROBE_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
    tx_strobe |-> state_code == 3'd5); // R5
  AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    state_code == 3'd1 |=> state_code == 3'd1 || state_code == 3'd7); // R8
  AST_WAKE_AT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    wake_irq |-> state_code == 3'd2 && $past(state_code) == 3'd7); // R8
  AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd5 && state_code != 3'd1 && state_code != 3'd2) |=> state_code == 3'd7); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err); // R12
endmodule

bind radio_state_seq radio_state_seq_chk u_chk (.*);

// File: tb/radio_state_seq_test.sv
module radio_state_seq_test;
  localparam int SLP_CYC = 35 * (100_000_000 / 4_000_000);

  logic clk = 1'b0, rst_n = 1'b0, us_tick = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic slp_pin = 1'b0, tx_done = 1'b0;
  logic [2:0] state_code;
  logic busy, wake_irq, tx_strobe, cmd_err;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  radio_state_seq #(.CLK_HZ(100_000_000), .CLKM_HZ(4_000_000)) uut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .slp_pin(slp_pin), .tx_done(tx_done),
    .state_code(state_code), .busy(busy), .wake_irq(wake_irq),
    .tx_strobe(tx_strobe), .cmd_err(cmd_err));

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk); cmd_valid = 1'b0; cmd_code = 3'd0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); us_tick = 1'b1;
      @(negedge clk); us_tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  // {err, target, delay}; delay 0 means the state is kept
  function automatic logic [12:0] plan_move(input logic [2:0] s, input logic [2:0] c);
    logic e; logic [2:0] t; logic [8:0] d;
    e = 1'b0; t = s; d = 9'd0;
    case (c)
      3'd1: if (s == 3'd3 || s == 3'd4) begin t = 3'd2; d = 9'd1; end
      3'd2: if (s == 3'd2) begin t = 3'd3; d = 9'd110; end
            else if (s == 3'd4) begin t = 3'd3; d = 9'd1; end
      3'd3: if (s == 3'd2) begin t = 3'd4; d = 9'd110; end
            else if (s == 3'd3) begin t = 3'd4; d = 9'd1; end
      3'd4: e = 1'b1;
      3'd5: if (s != 3'd2) begin t = 3'd2; d = 9'd1; end
      3'd6: if (s == 3'd4) begin t = 3'd3; d = 9'd1; end
      default: ;
    endcase
    return {e, t, d};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [2:0] cur, code;
    logic [12:0] p;
    logic exp_err;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 reset state", state_code, 0);
    chk("R1 reset err", cmd_err, 0);
    chk("R2 busy in reset", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    tick(36);
    chk("R1 still reset", state_code, 0);
    tick(1);
    chk("R1 reset exit", state_code, 2);

    send(3'd2);
    chk("R2 transition code", state_code, 7);
    chk("R2 busy", busy, 1);
    tick(109);
    chk("R3 before 110", state_code, 7);
    send(3'd3);
    chk("R11 discard state", state_code, 7);
    chk("R11 discard err", cmd_err, 0);
    tick(1);
    chk("R3 pll reached, R11 target kept", state_code, 3);

    send(3'd3);
    repeat (4) @(negedge clk);
    chk("R4 waits tick", state_code, 7);
    tick(1); chk("R4 pll->rx", state_code, 4);
    send(3'd2); tick(1); chk("R4 rx->pll", state_code, 3);
    send(3'd1); tick(1); chk("R4 pll->off", state_code, 2);

    @(negedge clk); slp_pin = 1'b1;
    repeat (SLP_CYC) @(negedge clk);
    chk("R7 last sleep wait", state_code, 7);
    @(negedge clk);
    chk("R7 sleep reached", state_code, 1);
    send(3'd5); chk("R9 force off in sleep", state_code, 1);
    send(3'd6); chk("R10 force pll in sleep", state_code, 1);
    chk("R10 no err", cmd_err, 0);

    @(negedge clk); slp_pin = 1'b0;
    @(negedge clk);
    chk("R8 wake transition", state_code, 7);
    tick(239);
    chk("R8 before 240", state_code, 7);
    chk("R8 no early irq", wake_irq, 0);
    tick(1);
    chk("R8 off reached", state_code, 2);
    chk("R8 irq", wake_irq, 1);
    @(negedge clk);
    chk("R8 irq one cycle", wake_irq, 0);

    send(3'd2); tick(110); chk("R3 pll again", state_code, 3);
    send(3'd4); chk("R5 busy_tx", state_code, 5);
    tick(15);
    chk("R5 no early strobe", tx_strobe, 0);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R6 early done ignored", state_code, 5);
    tick(1);
    chk("R5 strobe", tx_strobe, 1);
    @(negedge clk);
    chk("R5 strobe one cycle", tx_strobe, 0);
    @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0;
    chk("R6 tx end transition", state_code, 7);
    tick(31); chk("R6 before 32", state_code, 7);
    tick(1); chk("R6 pll after tx", state_code, 3);

    @(negedge clk); slp_pin = 1'b1;
    @(negedge clk);
    chk("R5 pin start", state_code, 5);
    send(3'd6); chk("R10 force pll from tx", state_code, 7);
    tick(1); chk("R10 pll reached", state_code, 3);
    @(negedge clk);
    chk("R5 level no restart", state_code, 3);
    slp_pin = 1'b0;
    send(3'd5); tick(1); chk("R9 force off from pll", state_code, 2);

    send(3'd2); tick(5);
    send(3'd5); tick(1); chk("R9 abort long", state_code, 2);
    send(3'd6); repeat (3) @(negedge clk);
    chk("R10 ignored in off", state_code, 2);
    chk("R10 ignored no err", cmd_err, 0);

    do_reset();
    send(3'd6); chk("R10 ignored in reset", state_code, 0);
    send(3'd5); tick(1); chk("R9 force off from reset", state_code, 2);
    send(3'd4);
    chk("R12 tx in off keeps state", state_code, 2);
    chk("R12 err set", cmd_err, 1);
    send(3'd2); tick(110); send(3'd4); send(3'd3);
    chk("R12 cmd in tx keeps state", state_code, 5);
    send(3'd5); tick(1);
    chk("R12 err sticky", cmd_err, 1);

    do_reset();
    chk("R1 err cleared", cmd_err, 0);
    tick(37);
    cur = 3'd2; exp_err = 1'b0;
    for (int i = 0; i < 60; i++) begin
      code = 3'($urandom_range(0, 7));
      if (code == 3'd4 && cur == 3'd3) code = 3'd0;
      p = plan_move(cur, code);
      send(code);
      exp_err = exp_err | p[12];
      if (p[8:0] != 0) begin
        chk("R3 random transition", state_code, 7);
        tick(int'(p[8:0]) - 1);
        chk("R4 random still moving", state_code, 7);
        tick(1);
        cur = p[11:9];
      end
      chk("R11 random state", state_code, cur);
      chk("R12 random err", cmd_err, exp_err);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule